// File: doc/BRIEF.md
# SCSI Data FIFO with Word-Wide DMA Port

This block is the data path between a SCSI controller's bus engine, its host processor and a DMA engine. It has a 16-byte FIFO that three ports can reach. The SCSI side pushes and pops single bytes. The processor reads and writes single bytes. The DMA port moves 16-bit words, which it unpacks into bytes or packs from bytes with the first byte in the low half. A swap input selects a big-endian host view, and this view exchanges the two halves of the word in both directions.

A transfer counter follows the bytes that the DMA port moves. When the counter first reaches zero, the block raises a terminal-count flag and records the FIFO fill level as the residual length. The DMA request (DRQ) comes from a small state machine with three states:

- `ST_IDLE`: no transfer.
- `ST_TO_HOST`: device to memory. DRQ is raised when the FIFO holds more bytes than a threshold. The threshold is 1 if the "keep odd byte" option is set, so that the processor can read the last byte itself, and 0 otherwise.
- `ST_FROM_HOST`: memory to device. DRQ is raised while the FIFO has room.

The state machine moves on three pulses:

- `xfer_start_in` goes to `ST_TO_HOST`.
- `xfer_start_out` goes to `ST_FROM_HOST`.
- `xfer_stop` goes to `ST_IDLE` and takes priority over both start pulses.

Top module: `scsi_dma_fifo`

## Requirements
- R1: After reset `fifo_level` is 0, `tc` is 0, `drq` is 0 and the state is `ST_IDLE`.
- R2: The FIFO holds up to 16 bytes and returns them in the order they were written. A push into a full FIFO is ignored. Only one access takes effect in a cycle, picked in this order: `dma_wr`, `dma_rd`, `dev_push`, `dev_pop`, `cpu_wr`, `cpu_rd`.
- R3: If at least two bytes are queued, a DMA word read returns the head byte in bits 7:0 and the next byte in bits 15:8. It removes both bytes and lowers the counter by 2.
- R4: If one byte is queued, a DMA word read returns that byte in bits 7:0 and 0xFF in bits 15:8, pops it, and lowers the counter by 1. If the FIFO is empty, the read returns 0xFF00 and changes nothing.
- R5: A DMA word write pushes bits 7:0 first and then bits 15:8, and lowers the counter by 2. If the FIFO already holds more than 14 bytes, or the counter equals 1, only bits 7:0 are pushed and the counter drops by 1. Nothing is pushed or counted when the FIFO is full.
- R6: With `dma_swap` at 1, the two bytes of the DMA word are exchanged before a write and after a read.
- R7: A `cnt_load` of value 0 sets the counter to 65536. Any other value sets the counter to that value. Decrements stop at zero.
- R8: `tc` rises only on the first decrement that reaches zero. At that moment `resid_len` takes the FIFO level that follows the access. Later decrements change neither signal, and a `cnt_load` clears `tc`.
- R9: In `ST_TO_HOST`, `drq` is 1 when the level is above 1 (with `cfg_keep_odd` at 1) or above 0 (with `cfg_keep_odd` at 0). With `cfg_sync` at 1, `drq` also requires `tc` to be 0.
- R10: In `ST_FROM_HOST`, `drq` is 1 when the level is below 16 and `tc` is 0. In `ST_IDLE`, `drq` is 0.
- R11: A DMA read with `dma_peek` at 1 returns the same data as a normal read but changes neither the FIFO nor the counter.
- R12: `xfer_stop` takes priority over both start pulses and moves the state to `ST_IDLE`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_keep_odd | input | 1 | Keep the last odd byte for the processor when moving data to the host |
| cfg_sync | input | 1 | Synchronous transfer mode; DRQ to the host also requires tc low |
| dma_swap | input | 1 | Exchange the two bytes of the DMA word |
| cnt_load | input | 1 | Load the transfer counter |
| cnt_value | input | 16 | Counter load value; 0 means 65536 |
| xfer_start_in | input | 1 | Start a device-to-memory transfer |
| xfer_start_out | input | 1 | Start a memory-to-device transfer |
| xfer_stop | input | 1 | End the transfer |
| cpu_wr | input | 1 | Processor byte push |
| cpu_wdata | input | 8 | Processor write byte |
| cpu_rd | input | 1 | Processor byte pop |
| cpu_rdata | output | 8 | Head byte, or 0 when empty |
| dev_push | input | 1 | SCSI-side byte push |
| dev_wdata | input | 8 | SCSI-side write byte |
| dev_pop | input | 1 | SCSI-side byte pop |
| dev_rdata | output | 8 | Head byte, or 0 when empty |
| dma_wr | input | 1 | DMA word write |
| dma_wdata | input | 16 | DMA write word |
| dma_rd | input | 1 | DMA word read |
| dma_peek | input | 1 | Read without side effects |
| dma_rdata | output | 16 | DMA read word |
| drq | output | 1 | DMA request |
| tc | output | 1 | Terminal count reached |
| xfer_left | output | 17 | Remaining transfer count |
| resid_len | output | 5 | FIFO level captured when tc rose |
| fifo_level | output | 5 | Bytes queued |

## Verification
The assertions check the following on every cycle:

- The fill level never goes past the depth.
- The counter never rises unless it is loaded.
- `tc` stays set and implies a zero count.
- DRQ follows the level and `tc` limits of each state and stays low in `ST_IDLE`.
- A stop pulse always leads to `ST_IDLE`.
- A peek read leaves the level and count unchanged.

Only the bench's scenarios can show the following:

- The byte order of packed and unpacked words, with and without the swap.
- The fallback to a single byte at 15 queued bytes or a count of 1.
- The 0xFF fill of a short read.
- The value captured in `resid_len`.
- The access priority when several ports are used in the same cycle.

// File: rtl/sfd_pkg.sv
package sfd_pkg;
    typedef enum logic [1:0] {
        ST_IDLE      = 2'd0,
        ST_TO_HOST   = 2'd1,
        ST_FROM_HOST = 2'd2
    } xfer_state_t;
endpackage

// File: rtl/sfd_byte_fifo.sv
module sfd_byte_fifo #(
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       push_n,
    input  logic [7:0]       push_b0,
    input  logic [7:0]       push_b1,
    input  logic [1:0]       pop_n,
    output logic [7:0]       head0,
    output logic [7:0]       head1,
    output logic [LVL_W-1:0] level
);
    logic [7:0]       mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [PTR_W-1:0] wr_ptr_p1;
    logic [PTR_W-1:0] rd_ptr_p1;

    assign wr_ptr_p1 = wr_ptr + PTR_W'(1);
    assign rd_ptr_p1 = rd_ptr + PTR_W'(1);
    assign head0     = mem[rd_ptr];
    assign head1     = mem[rd_ptr_p1];

    always_ff @(posedge clk) begin
        if (push_n != 2'd0) mem[wr_ptr] <= push_b0;
        if (push_n == 2'd2) mem[wr_ptr_p1] <= push_b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            wr_ptr <= wr_ptr + PTR_W'(push_n);
            rd_ptr <= rd_ptr + PTR_W'(pop_n);
            level  <= level + LVL_W'(push_n) - LVL_W'(pop_n);
        end
    end
endmodule

// File: rtl/sfd_xfer_counter.sv
module sfd_xfer_counter #(
    parameter int CNT_W = 16,
    parameter int LVL_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic [1:0]       dec,
    input  logic [LVL_W-1:0] level_next,
    output logic [CNT_W:0]   left,
    output logic             tc,
    output logic [LVL_W-1:0] resid
);
    logic [CNT_W:0] left_dec;

    always_comb begin
        if (left > (CNT_W+1)'(dec)) left_dec = left - (CNT_W+1)'(dec);
        else                        left_dec = '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left  <= '0;
            tc    <= 1'b0;
            resid <= '0;
        end else if (load) begin
            left <= (load_val == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, load_val};
            tc   <= 1'b0;
        end else if (dec != 2'd0) begin
            left <= left_dec;
            if (left_dec == '0 && !tc) begin
                tc    <= 1'b1;
                resid <= level_next;
            end
        end
    end
endmodule

// File: rtl/sfd_drq_fsm.sv
module sfd_drq_fsm
    import sfd_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_in,
    input  logic             start_out,
    input  logic             stop,
    input  logic             keep_odd,
    input  logic             sync_mode,
    input  logic             tc,
    input  logic [LVL_W-1:0] level,
    output xfer_state_t      state,
    output logic             drq
);
    xfer_state_t state_nxt;

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (stop)           state_nxt = ST_IDLE;
                else if (start_in)  state_nxt = ST_TO_HOST;
                else if (start_out) state_nxt = ST_FROM_HOST;
            end
            ST_TO_HOST: begin
                if (stop)           state_nxt = ST_IDLE;
                else if (start_out) state_nxt = ST_FROM_HOST;
            end
            ST_FROM_HOST: begin
                if (stop)           state_nxt = ST_IDLE;
                else if (start_in)  state_nxt = ST_TO_HOST;
            end
            default: state_nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_comb begin
        drq = 1'b0;
        unique case (state)
            ST_IDLE:      drq = 1'b0;
            ST_TO_HOST:   drq = (level > (keep_odd ? LVL_W'(1) : LVL_W'(0)))
                                && !(sync_mode && tc);
            ST_FROM_HOST: drq = (level < LVL_W'(DEPTH)) && !tc;
            default:      drq = 1'b0;
        endcase
    end
endmodule

// File: rtl/scsi_dma_fifo.sv
module scsi_dma_fifo
    import sfd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_keep_odd,
    input  logic             cfg_sync,
    input  logic             dma_swap,
    input  logic             cnt_load,
    input  logic [CNT_W-1:0] cnt_value,
    input  logic             xfer_start_in,
    input  logic             xfer_start_out,
    input  logic             xfer_stop,
    input  logic             cpu_wr,
    input  logic [7:0]       cpu_wdata,
    input  logic             cpu_rd,
    output logic [7:0]       cpu_rdata,
    input  logic             dev_push,
    input  logic [7:0]       dev_wdata,
    input  logic             dev_pop,
    output logic [7:0]       dev_rdata,
    input  logic             dma_wr,
    input  logic [15:0]      dma_wdata,
    input  logic             dma_rd,
    input  logic             dma_peek,
    output logic [15:0]      dma_rdata,
    output logic             drq,
    output logic             tc,
    output logic [CNT_W:0]   xfer_left,
    output logic [LVL_W-1:0] resid_len,
    output logic [LVL_W-1:0] fifo_level
);
    logic [1:0]       push_n, pop_n, dec;
    logic [7:0]       push_b0, push_b1, head0, head1;
    logic [15:0]      wr_word, rd_raw;
    logic [LVL_W-1:0] level_next;
    logic             room_one, has_one, has_two, single_wr;
    xfer_state_t      xfer_state;

    assign room_one  = fifo_level < LVL_W'(DEPTH);
    assign has_one   = fifo_level != '0;
    assign has_two   = fifo_level >= LVL_W'(2);
    assign single_wr = (fifo_level > LVL_W'(DEPTH - 2)) || (xfer_left == (CNT_W+1)'(1));
    assign wr_word   = dma_swap ? {dma_wdata[7:0], dma_wdata[15:8]} : dma_wdata;

    always_comb begin
        push_n  = 2'd0;
        pop_n   = 2'd0;
        dec     = 2'd0;
        push_b0 = 8'h00;
        push_b1 = 8'h00;
        if (dma_wr) begin
            push_b0 = wr_word[7:0];
            push_b1 = wr_word[15:8];
            if (!single_wr) begin
                push_n = 2'd2;
                dec    = 2'd2;
            end else if (room_one) begin
                push_n = 2'd1;
                dec    = 2'd1;
            end
        end else if (dma_rd) begin
            if (!dma_peek && has_two) begin
                pop_n = 2'd2;
                dec   = 2'd2;
            end else if (!dma_peek && has_one) begin
                pop_n = 2'd1;
                dec   = 2'd1;
            end
        end else if (dev_push) begin
            push_b0 = dev_wdata;
            if (room_one) push_n = 2'd1;
        end else if (dev_pop) begin
            if (has_one) pop_n = 2'd1;
        end else if (cpu_wr) begin
            push_b0 = cpu_wdata;
            if (room_one) push_n = 2'd1;
        end else if (cpu_rd) begin
            if (has_one) pop_n = 2'd1;
        end
    end

    assign level_next = fifo_level + LVL_W'(push_n) - LVL_W'(pop_n);

    always_comb begin
        if (has_two)      rd_raw = {head1, head0};
        else if (has_one) rd_raw = {8'hFF, head0};
        else              rd_raw = 16'hFF00;
    end

    assign dma_rdata = dma_swap ? {rd_raw[7:0], rd_raw[15:8]} : rd_raw;
    assign cpu_rdata = has_one ? head0 : 8'h00;
    assign dev_rdata = has_one ? head0 : 8'h00;

    sfd_byte_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk(clk), .rst_n(rst_n),
        .push_n(push_n), .push_b0(push_b0), .push_b1(push_b1),
        .pop_n(pop_n), .head0(head0), .head1(head1), .level(fifo_level)
    );

    sfd_xfer_counter #(.CNT_W(CNT_W), .LVL_W(LVL_W)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .load(cnt_load), .load_val(cnt_value), .dec(dec),
        .level_next(level_next), .left(xfer_left), .tc(tc), .resid(resid_len)
    );

    sfd_drq_fsm #(.DEPTH(DEPTH)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .start_in(xfer_start_in), .start_out(xfer_start_out), .stop(xfer_stop),
        .keep_odd(cfg_keep_odd), .sync_mode(cfg_sync), .tc(tc),
        .level(fifo_level), .state(xfer_state), .drq(drq)
    );
endmodule

// File: rtl/sfd_checker.sv
module sfd_checker
    import sfd_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = 16,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_keep_odd,
    input logic             cnt_load,
    input logic             xfer_stop,
    input logic             dma_wr,
    input logic             dma_rd,
    input logic             dma_peek,
    input logic             drq,
    input logic             tc,
    input logic [CNT_W:0]   xfer_left,
    input logic [LVL_W-1:0] fifo_level,
    input xfer_state_t      xfer_state
);
    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_level <= LVL_W'(DEPTH));

    p_count_down_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cnt_load |=> xfer_left <= $past(xfer_left));

    p_tc_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc && !cnt_load |=> tc);

    p_tc_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tc |-> xfer_left == '0);

    p_drq_in_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_state == ST_TO_HOST) && drq |->
            fifo_level > (cfg_keep_odd ? LVL_W'(1) : LVL_W'(0)));

    p_drq_out_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_state == ST_FROM_HOST) && drq |-> (fifo_level < LVL_W'(DEPTH)) && !tc);

    p_drq_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_state == ST_IDLE) |-> !drq);

    p_peek_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        dma_rd && dma_peek && !dma_wr && !cnt_load |=>
            $stable(fifo_level) && $stable(xfer_left));

    p_stop_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_stop |=> xfer_state == ST_IDLE);
endmodule

bind scsi_dma_fifo sfd_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_sfd_chk (
    .clk(clk), .rst_n(rst_n), .cfg_keep_odd(cfg_keep_odd), .cnt_load(cnt_load),
    .xfer_stop(xfer_stop), .dma_wr(dma_wr), .dma_rd(dma_rd), .dma_peek(dma_peek),
    .drq(drq), .tc(tc), .xfer_left(xfer_left), .fifo_level(fifo_level),
    .xfer_state(xfer_state)
);

// File: tb/scsi_dma_fifo_bench.sv
module scsi_dma_fifo_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_keep_odd, cfg_sync, dma_swap, cnt_load;
    logic [15:0] cnt_value;
    logic        xfer_start_in, xfer_start_out, xfer_stop;
    logic        cpu_wr, cpu_rd, dev_push, dev_pop, dma_wr, dma_rd, dma_peek;
    logic [7:0]  cpu_wdata, dev_wdata, cpu_rdata, dev_rdata;
    logic [15:0] dma_wdata, dma_rdata;
    logic        drq, tc;
    logic [16:0] xfer_left;
    logic [4:0]  resid_len, fifo_level;

    int n_checks = 0;
    int n_fail   = 0;

    // {op, din, expected read word, expected level, expected count, expected drq}
    // op 0 = SCSI-side push, op 1 = DMA word read
    localparam logic [55:0] VEC [8] = '{
        56'h0_11_0000_01_000A_1,
        56'h0_22_0000_02_000A_1,
        56'h0_33_0000_03_000A_1,
        56'h1_00_2211_01_0008_1,
        56'h1_00_FF33_00_0007_0,
        56'h0_44_0000_01_0007_1,
        56'h0_55_0000_02_0007_1,
        56'h1_00_5544_00_0005_0
    };

    always #(CLK_PERIOD/2) clk = ~clk;

    scsi_dma_fifo u_scsi_dma_fifo (
        .clk(clk), .rst_n(rst_n), .cfg_keep_odd(cfg_keep_odd), .cfg_sync(cfg_sync),
        .dma_swap(dma_swap), .cnt_load(cnt_load), .cnt_value(cnt_value),
        .xfer_start_in(xfer_start_in), .xfer_start_out(xfer_start_out), .xfer_stop(xfer_stop),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd), .cpu_rdata(cpu_rdata),
        .dev_push(dev_push), .dev_wdata(dev_wdata), .dev_pop(dev_pop), .dev_rdata(dev_rdata),
        .dma_wr(dma_wr), .dma_wdata(dma_wdata), .dma_rd(dma_rd), .dma_peek(dma_peek),
        .dma_rdata(dma_rdata), .drq(drq), .tc(tc), .xfer_left(xfer_left),
        .resid_len(resid_len), .fifo_level(fifo_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_pulses();
        cnt_load = 0; xfer_start_in = 0; xfer_start_out = 0; xfer_stop = 0;
        cpu_wr = 0; cpu_rd = 0; dev_push = 0; dev_pop = 0;
        dma_wr = 0; dma_rd = 0; dma_peek = 0;
    endtask

    // finish the cycle whose inputs are driven, then settle
    task automatic tick();
        @(posedge clk); #1;
        clear_pulses();
        #1;
    endtask

    task automatic do_reset();
        rst_n = 0; clear_pulses();
        cfg_keep_odd = 0; cfg_sync = 0; dma_swap = 0;
        cnt_value = 0; cpu_wdata = 0; dev_wdata = 0; dma_wdata = 0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1; #1;
    endtask

    task automatic load_cnt(input logic [15:0] v);
        cnt_load = 1; cnt_value = v; tick();
    endtask

    task automatic push_dev(input logic [7:0] d);
        dev_push = 1; dev_wdata = d; tick();
    endtask

    task automatic dma_write(input logic [15:0] w);
        dma_wr = 1; dma_wdata = w; tick();
    endtask

    task automatic dma_read(input string tag, input logic [15:0] exp);
        dma_rd = 1; #1;
        chk(tag, dma_rdata, exp);
        tick();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_fail++;
        $display("FAIL R1 watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        chk("R1 level after reset", fifo_level, 0);
        chk("R1 tc after reset", tc, 0);
        chk("R1 drq after reset", drq, 0);

        // R3 R4 table: to-host transfer, counter 10
        load_cnt(16'd10);
        xfer_start_in = 1; tick();
        for (int i = 0; i < 8; i++) begin
            if (VEC[i][55:52] == 4'h0) begin
                push_dev(VEC[i][51:44]);
            end else begin
                dma_read("R3 R4 table read word", VEC[i][43:28]);
            end
            chk("R3 table level", fifo_level, VEC[i][27:20]);
            chk("R3 table count", xfer_left, VEC[i][19:4]);
            chk("R9 table drq", drq, VEC[i][3:0]);
        end

        // R5 R8 R10: from-host writes, count-1 fallback, terminal count
        do_reset();
        load_cnt(16'd5);
        xfer_start_out = 1; tick();
        chk("R10 drq from host empty", drq, 1);
        dma_write(16'hBBAA);
        chk("R5 level after word write", fifo_level, 2);
        chk("R5 count after word write", xfer_left, 3);
        chk("R5 low byte first", dev_rdata, 8'hAA);
        dev_pop = 1; tick();
        chk("R5 high byte second", dev_rdata, 8'hBB);
        dev_pop = 1; tick();
        dma_write(16'hDDCC);
        chk("R5 count 1", xfer_left, 1);
        dma_write(16'hFFEE);
        chk("R5 count-1 fallback level", fifo_level, 3);
        chk("R8 tc rises", tc, 1);
        chk("R8 residual captured", resid_len, 3);
        chk("R10 drq low after tc", drq, 0);
        dma_write(16'h2211);
        chk("R7 count saturates", xfer_left, 0);
        chk("R8 residual held", resid_len, 3);
        chk("R8 tc held", tc, 1);
        chk("R5 level after saturated write", fifo_level, 5);

        // R5 R2 R10: near-full fallback, full ignore, ordering
        do_reset();
        load_cnt(16'd100);
        xfer_start_out = 1; tick();
        for (int i = 0; i < 15; i++) begin
            cpu_wr = 1; cpu_wdata = 8'hA0 + 8'(i); tick();
        end
        dma_write(16'h2211);
        chk("R5 near-full single byte level", fifo_level, 16);
        chk("R5 near-full count", xfer_left, 99);
        chk("R10 drq low when full", drq, 0);
        dma_write(16'h4433);
        chk("R2 full push ignored level", fifo_level, 16);
        chk("R5 full write not counted", xfer_left, 99);
        for (int i = 0; i < 16; i++) begin
            chk("R2 byte order", cpu_rdata, (i < 15) ? 8'hA0 + 8'(i) : 8'h11);
            cpu_rd = 1; tick();
        end
        chk("R2 drained", fifo_level, 0);
        dev_push = 1; dev_wdata = 8'h5A; cpu_wr = 1; cpu_wdata = 8'hA5; tick();
        chk("R2 priority one access", fifo_level, 1);
        chk("R2 priority winner", dev_rdata, 8'h5A);
        xfer_start_in = 1; xfer_stop = 1; tick();
        chk("R12 stop wins drq", drq, 0);
        xfer_start_in = 1; tick();
        chk("R12 start after stop", drq, 1);
        load_cnt(16'd0);
        chk("R7 zero load", xfer_left, 17'h10000);

        // R6 R11 R4 R9: swap, peek, empty read, keep-odd and sync rules
        do_reset();
        load_cnt(16'd10);
        xfer_start_in = 1; tick();
        push_dev(8'h12);
        push_dev(8'h34);
        dma_swap = 1;
        dma_read("R6 swapped read", 16'h1234);
        chk("R6 count after swapped read", xfer_left, 8);
        dma_write(16'hABCD);
        chk("R6 swapped write first byte", dev_rdata, 8'hAB);
        dma_swap = 0;
        dma_rd = 1; dma_peek = 1; #1;
        chk("R11 peek data", dma_rdata, 16'hCDAB);
        tick();
        chk("R11 peek level", fifo_level, 2);
        chk("R11 peek count", xfer_left, 6);
        dev_pop = 1; tick();
        dev_pop = 1; tick();
        dma_read("R4 empty read", 16'hFF00);
        chk("R4 empty read count", xfer_left, 6);
        cfg_keep_odd = 1;
        push_dev(8'h61);
        chk("R9 keep odd one byte", drq, 0);
        push_dev(8'h62);
        chk("R9 keep odd two bytes", drq, 1);
        cfg_keep_odd = 0;
        dma_read("R3 read", 16'h6261);
        load_cnt(16'd2);
        push_dev(8'h51);
        push_dev(8'h52);
        push_dev(8'h53);
        dma_read("R3 read to zero", 16'h5251);
        chk("R8 tc on read", tc, 1);
        chk("R8 residual on read", resid_len, 1);
        chk("R9 async drq after tc", drq, 1);
        cfg_sync = 1; #1;
        chk("R9 sync drq after tc", drq, 0);
        load_cnt(16'd3);
        chk("R8 load clears tc", tc, 0);
        chk("R9 sync drq after reload", drq, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule